// File: doc/BRIEF.md
# Clear-on-Read Interrupt Aggregator

This block collects edge events from 22 asynchronous inputs and presents them to a host as three 8-bit pending registers. Each pending register has its own mask register. Every input first passes through a two-flop synchronizer. An edge detector then runs on each input, and each input has its own sensitivity: rising, falling or both. An edge on an unmasked input sets a sticky pending bit.

The host sees a single active-low interrupt line, modelled as an open-drain pull-down (`irq_n`). The line stays low while any pending bit is set. Reading a pending register returns its contents and clears it in the same access. The line is released only once every pending register has been read empty.

Register access uses a simple strobe port. `rd_en` or `wr_en` is sampled together with `addr` on a clock edge, and read data appears registered one cycle later. The bus protocol that sits in front of this port is not part of the block.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all six registers read 0x00 and `irq_n` is 1.
- R2: Address 2k selects pending register k and address 2k+1 selects mask register k, for k = 0..2. Mask registers can be read and written. `rd_data` holds the selected value on the clock cycle after the edge that samples `rd_en`.
- R3: Input i maps to register i/8, bit i%8. Register 2 bits 6 and 7 have no input: they always read 0 and cannot be unmasked, so writing 0xFF to mask register 2 reads back 0x3F.
- R4: The sensitivity of input i is `edge_cfg[2i+1:2i]`: 00 means rising only, 01 means falling only, and 10 or 11 means both edges. An edge of the other direction sets nothing.
- R5: An edge on an unmasked input sets its pending bit on the third clock edge after the input changes. The bit stays set until its register is read.
- R6: An edge on a masked input never sets its bit. Unmasking the input later does not report edges that occurred while it was masked.
- R7: Reading a pending register returns its value and clears it. The other registers are not affected.
- R8: An event that arrives on the same edge as a read-clear of its register survives, and is returned by the next read.
- R9: `irq_n` is 0 while any pending bit is set. It returns to 1 only after every pending register has been read.
- R10: Writes to pending register addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 22 | Asynchronous interrupt inputs |
| edge_cfg | input | 44 | Two sensitivity bits per input |
| rd_en | input | 1 | Read strobe (clears a pending register) |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low shared interrupt (0 = pull low) |

## Verification
The bench drives rising and falling pulses into inputs configured for rising-only, falling-only and both-edge sensitivity. This separates correct edge qualification from plain level or any-change detection. The bench also sets bits pending in two registers at once, and then reads them one at a time, which shows that the line is released only when the last register has been read. A masked edge followed by unmasking checks that no event is reported after the fact. An edge timed to land exactly on a read-clear edge checks that an event arriving during a clear is not lost.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  // Decide whether a transition prv -> cur qualifies under sel
  function automatic logic edge_hit(logic [1:0] sel, logic cur, logic prv);
    logic rise;
    logic fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    case (edge_sel_e'(sel))
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      default:   edge_hit = rise | fall;
    endcase
  endfunction

  // Bits of register 'bank' that are backed by a real input
  function automatic logic [31:0] bank_mask(int unsigned bank, int unsigned nsrc,
                                            int unsigned w);
    logic [31:0] m;
    m = '0;
    for (int unsigned b = 0; b < 32; b++) begin
      if (b < w && (bank * w + b) < nsrc) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqagg_edge.sv
module irqagg_edge
  import irqagg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   sync_in,
  input  logic [2*W-1:0] cfg,
  output logic [W-1:0]   evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_in;
  end

  for (genvar i = 0; i < W; i++) begin : g_det
    assign evt[i] = edge_hit(cfg[2*i +: 2], sync_in[i], prev_q[i]);
  end

  // R4
  edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~(sync_in ^ $past(sync_in))) == '0);
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank #(
  parameter int           W     = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         en_wr,
  input  logic [W-1:0] wr_data,
  input  logic         rd_clr,
  output logic [W-1:0] status_q,
  output logic [W-1:0] enable_q
);
  logic [W-1:0] latch_set;
  logic [W-1:0] status_d;

  assign latch_set = evt & enable_q;
  assign status_d  = (rd_clr ? '0 : status_q) | latch_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      if (en_wr) enable_q <= wr_data & VALID;
    end
  end

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~$past(status_q) & ~$past(enable_q)) == '0);

  // R7
  rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (status_q == $past(evt & enable_q)));

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> (($past(status_q) & ~status_q) == '0));

  // R3
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | enable_q) & ~VALID) == '0);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int  NUM_SRC     = 22,
  parameter int  REG_W       = 8,
  parameter int  SYNC_STAGES = 2,
  localparam int NUM_BANK    = (NUM_SRC + REG_W - 1) / REG_W,
  localparam int ADDR_W      = $clog2(2 * NUM_BANK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_in,
  input  logic [2*NUM_SRC-1:0] edge_cfg,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_data,
  output logic                 irq_n
);
  localparam int PAD_W = NUM_BANK * REG_W;

  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] evt;
  logic [PAD_W-1:0]   evt_pad;
  logic [REG_W-1:0]   status_arr [NUM_BANK];
  logic [REG_W-1:0]   enable_arr [NUM_BANK];
  logic [NUM_BANK-1:0] bank_pending;
  logic [REG_W-1:0]   rd_mux;

  irqagg_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_in), .q(src_sync)
  );

  irqagg_edge #(.W(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .sync_in(src_sync), .cfg(edge_cfg), .evt(evt)
  );

  always_comb begin
    evt_pad = '0;
    evt_pad[NUM_SRC-1:0] = evt;
  end

  for (genvar k = 0; k < NUM_BANK; k++) begin : g_bank
    localparam logic [31:0]       MK     = bank_mask(k, NUM_SRC, REG_W);
    localparam logic [ADDR_W-1:0] ST_ADR = ADDR_W'(2 * k);
    localparam logic [ADDR_W-1:0] EN_ADR = ADDR_W'(2 * k + 1);
    logic rd_clr;
    logic en_wr;

    assign rd_clr = rd_en && (addr == ST_ADR);
    assign en_wr  = wr_en && (addr == EN_ADR);

    irqagg_bank #(.W(REG_W), .VALID(MK[REG_W-1:0])) u_bank (
      .clk(clk), .rst_n(rst_n),
      .evt(evt_pad[k*REG_W +: REG_W]),
      .en_wr(en_wr), .wr_data(wr_data), .rd_clr(rd_clr),
      .status_q(status_arr[k]), .enable_q(enable_arr[k])
    );

    assign bank_pending[k] = |status_arr[k];
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_BANK; k++) begin
      if (addr == ADDR_W'(2 * k))     rd_mux = status_arr[k];
      if (addr == ADDR_W'(2 * k + 1)) rd_mux = enable_arr[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign irq_n = ~|bank_pending;

  // R9
  line_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(rd_en));

  // R9
  line_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(|evt));
endmodule

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] src_in = '0;
  logic [43:0] edge_cfg = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .edge_cfg(edge_cfg),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  // monitor: compare each read result against the scoreboard
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(logic [2:0] a, logic [7:0] e, string t);
    addr = a;
    rd_en = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(logic [2:0] a, logic [7:0] d);
    addr = a;
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_irq(logic e, string t);
    checks++;
    if (irq_n !== e) begin
      errors++;
      $display("FAIL %s: irq_n=%b expected %b", t, irq_n, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // inputs 0..7 rising, 8..15 falling, 16..21 both (R4 encoding)
    for (int i = 0; i < 22; i++)
      edge_cfg[2*i +: 2] = (i < 8) ? 2'b00 : (i < 16) ? 2'b01 : 2'b10;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    chk_irq(1'b1, "R1 irq after reset");
    for (int a = 0; a < 6; a++) do_read(3'(a), 8'h00, "R1 reset value");

    // R2 mask read/write, R3 unused bits
    do_write(3'd1, 8'hFF);
    do_write(3'd3, 8'hFF);
    do_write(3'd5, 8'hFF);
    do_read(3'd1, 8'hFF, "R2 mask0 readback");
    do_read(3'd3, 8'hFF, "R2 mask1 readback");
    do_read(3'd5, 8'h3F, "R3 mask2 unused bits");

    // R5 / R7 / R9 basic latch and clear
    src_in[0] = 1'b1;
    wait_cyc(4);
    chk_irq(1'b0, "R9 line asserted");
    do_read(3'd0, 8'h01, "R5 input0 rising latched");
    do_read(3'd0, 8'h00, "R7 cleared by read");
    chk_irq(1'b1, "R9 line released");

    // R4 direction qualification
    src_in[0] = 1'b0;
    wait_cyc(4);
    do_read(3'd0, 8'h00, "R4 falling ignored on rising input");
    src_in[8] = 1'b1;
    wait_cyc(4);
    do_read(3'd2, 8'h00, "R4 rising ignored on falling input");
    src_in[8] = 1'b0;
    wait_cyc(4);
    src_in[16] = 1'b1;
    wait_cyc(4);
    do_read(3'd2, 8'h01, "R4 falling input8 latched");
    chk_irq(1'b0, "R9 still pending in reg2");
    do_read(3'd4, 8'h01, "R4 both-edge rise");
    chk_irq(1'b1, "R9 released after last read");
    src_in[16] = 1'b0;
    wait_cyc(4);
    do_read(3'd4, 8'h01, "R4 both-edge fall");

    // R10 writes to pending address ignored; R3 mapping
    src_in[21] = 1'b1;
    wait_cyc(4);
    do_write(3'd4, 8'h00);
    do_read(3'd4, 8'h20, "R10 write ignored / R3 input21 at bit5");
    src_in[15] = 1'b1;
    wait_cyc(4);
    src_in[15] = 1'b0;
    wait_cyc(4);
    do_read(3'd2, 8'h80, "R3 input15 at reg1 bit7");

    // R6 masked input
    do_write(3'd1, 8'hFE & 8'hFD);
    do_read(3'd1, 8'hFC, "R2 mask0 partial");
    src_in[1] = 1'b1;
    wait_cyc(4);
    chk_irq(1'b1, "R6 masked edge no line");
    do_read(3'd0, 8'h00, "R6 masked edge not latched");
    do_write(3'd1, 8'hFF);
    wait_cyc(3);
    do_read(3'd0, 8'h00, "R6 no report after unmask");
    src_in[2] = 1'b1;
    wait_cyc(4);
    do_read(3'd0, 8'h04, "R6 unmasked input2 latched");

    // R8 event coincident with clear
    src_in[3] = 1'b1;
    wait_cyc(2);
    do_read(3'd0, 8'h00, "R8 read on event edge");
    do_read(3'd0, 8'h08, "R8 event kept");
    chk_irq(1'b1, "R9 released at end");

    wait_cyc(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule